// File: doc/BRIEF.md
# Complementary Output Generator with Coded Dead Band

This block turns a single PWM reference into a complementary output pair: a main output that follows the reference and a complement that follows its inverse. At every reference edge the output that is about to switch off drops in the very next cycle. The output that is about to switch on waits out a dead band, so the two are never active together and a half-bridge never shoots through.

The dead band is programmed as an 8-bit code with a nonlinear step encoding in four ranges. Short delays get fine steps and long delays get coarse steps with an offset. The decoded count is measured in base ticks, and one base tick is `TICK_DIV` clock cycles. A write port loads the code together with an output-enable bit and a break enable/polarity pair. While the lock level input is nonzero, every such write is discarded. A break input, when enabled and at its active polarity, forces both outputs low.

Top module: `deadband_gen`

## Requirements
- R1: After synchronous reset both outputs are low and the outputs are disabled, so toggling the reference before any configuration write leaves both outputs low.
- R2: A code with bit 7 clear gives a dead band equal to the code value in base ticks (code 0x7F gives 127 ticks).
- R3: A code whose bits 7:6 are 10 gives a dead band of (64 + bits 5:0) times 2 base ticks (0x81 gives 130, 0xBF gives 254).
- R4: A code whose bits 7:5 are 110 gives a dead band of (32 + bits 4:0) times 8 base ticks (0xC2 gives 272).
- R5: A code whose bits 7:5 are 111 gives a dead band of (32 + bits 4:0) times 16 base ticks (0xE1 gives 528, 0xFF gives 1008).
- R6: A reference change sampled at clock edge E drives the outgoing output low after edge E. The incoming output goes high after edge E + DT·TICK_DIV, where DT is the decoded tick count.
- R7: If the reference changes again at or before the edge on which the dead band would expire, the delayed output never goes high during that pulse.
- R8: While lock_lvl is nonzero, writes to the code, output enable, break enable and break polarity have no effect.
- R9: With break enabled, brk_in equal to the break polarity bit (1 = active high, 0 = active low) forces both outputs low after the next clock edge. The outputs return to the reference level when break is released. With break disabled, brk_in has no effect.
- R10: With the output enable bit written to 0, both outputs stay low whatever the reference does.
- R11: Code 0x00 gives no dead band: both outputs switch after the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | PWM reference, synchronous to clk |
| wr_en | input | 1 | Configuration write strobe |
| wr_code | input | 8 | Dead-band code to write |
| wr_out_en | input | 1 | Output enable to write |
| wr_brk_en | input | 1 | Break enable to write |
| wr_brk_pol | input | 1 | Break polarity to write (1 = active high) |
| lock_lvl | input | LOCK_W | Write-protect level; nonzero blocks writes |
| brk_in | input | 1 | Break request |
| out_hi | output | 1 | Main output, active high |
| out_lo | output | 1 | Complementary output, active high |

## Verification
The bench builds the block with TICK_DIV set to 2. Each base tick then spans two clocks, which exercises the reload of the tick prescaler on every reference edge and makes every delay an even cycle count. At that setting the widest code, 0xFF, takes 2016 cycles, so all four code ranges can be measured at both ends within the run. The bench also covers pulses shorter than and exactly equal to the dead band, and break at both polarities.

// File: rtl/deadband_pkg.sv
package deadband_pkg;

    localparam int CODE_W = 8;
    localparam int DT_W   = 10;

    typedef enum logic [1:0] {
        RNG_FINE,
        RNG_X2,
        RNG_X8,
        RNG_X16
    } db_range_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              out_en;
        logic              brk_en;
        logic              brk_pol;
    } db_cfg_t;

    function automatic db_range_e range_of(logic [CODE_W-1:0] c);
        if (!c[7])      return RNG_FINE;
        else if (!c[6]) return RNG_X2;
        else if (!c[5]) return RNG_X8;
        else            return RNG_X16;
    endfunction

    function automatic logic [DT_W-1:0] dt_decode(logic [CODE_W-1:0] c);
        logic [DT_W-1:0] d;
        unique case (range_of(c))
            RNG_FINE: d = {2'b00, c};
            RNG_X2:   d = (DT_W'(64) + {4'b0000, c[5:0]}) << 1;
            RNG_X8:   d = (DT_W'(32) + {5'b00000, c[4:0]}) << 3;
            default:  d = (DT_W'(32) + {5'b00000, c[4:0]}) << 4;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/deadband_cfg.sv
module deadband_cfg
    import deadband_pkg::*;
#(
    parameter int LOCK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  db_cfg_t           wr_data,
    input  logic [LOCK_W-1:0] lock_lvl,
    output db_cfg_t           cfg_q
);

    logic wr_ok;
    assign wr_ok = wr_en && (lock_lvl == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_ok) begin
            cfg_q <= wr_data;
        end
    end

    // R8: a nonzero lock level freezes every configuration field
    a_r8_lock_hold: assert property (@(posedge clk) disable iff (rst)
        (lock_lvl != '0) |=> $stable(cfg_q));

endmodule

// File: rtl/deadband_timer.sv
module deadband_timer
    import deadband_pkg::*;
#(
    parameter int TICK_DIV = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ref_in,
    input  logic [DT_W-1:0] dt_ticks,
    output logic            lvl,
    output logic            done
);

    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic            ref_q;
    logic            edge_det;
    logic            step;
    logic [DT_W-1:0] tcnt;

    assign edge_det = ref_in ^ ref_q;

    generate
        if (TICK_DIV == 1) begin : g_no_pre
            assign step = 1'b1;
        end else begin : g_pre
            logic [PRE_W-1:0] pre;
            always_ff @(posedge clk) begin
                if (rst || edge_det) begin
                    pre <= PRE_W'(TICK_DIV - 1);
                end else if (tcnt != '0) begin
                    pre <= (pre == '0) ? PRE_W'(TICK_DIV - 1) : pre - 1'b1;
                end
            end
            assign step = (pre == '0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
            tcnt  <= '0;
        end else begin
            ref_q <= ref_in;
            if (edge_det) begin
                tcnt <= dt_ticks;
            end else if (tcnt != '0 && step) begin
                tcnt <= tcnt - 1'b1;
            end
        end
    end

    assign lvl  = ref_q;
    assign done = (tcnt == '0);

    // R6: a reference edge with a nonzero dead band blanks the incoming side
    a_r6_edge_blank: assert property (@(posedge clk) disable iff (rst)
        (edge_det && dt_ticks != '0) |=> !done);

    // R6: between edges the count only holds or drops by one
    a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
        (!edge_det && tcnt != '0) |=>
        (tcnt == $past(tcnt) || tcnt == $past(tcnt) - 1'b1));

endmodule

// File: rtl/deadband_gen.sv
module deadband_gen
    import deadband_pkg::*;
#(
    parameter int TICK_DIV = 1,
    parameter int LOCK_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_in,
    input  logic              wr_en,
    input  logic [7:0]        wr_code,
    input  logic              wr_out_en,
    input  logic              wr_brk_en,
    input  logic              wr_brk_pol,
    input  logic [LOCK_W-1:0] lock_lvl,
    input  logic              brk_in,
    output logic              out_hi,
    output logic              out_lo
);

    db_cfg_t         wr_data;
    db_cfg_t         cfg_q;
    logic [DT_W-1:0] dt_ticks;
    logic            lvl;
    logic            done;
    logic            brk_act;
    logic            drive_ok;

    assign wr_data = '{code: wr_code, out_en: wr_out_en,
                       brk_en: wr_brk_en, brk_pol: wr_brk_pol};

    deadband_cfg #(.LOCK_W(LOCK_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .lock_lvl (lock_lvl),
        .cfg_q    (cfg_q)
    );

    assign dt_ticks = dt_decode(cfg_q.code);

    deadband_timer #(.TICK_DIV(TICK_DIV)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .ref_in   (ref_in),
        .dt_ticks (dt_ticks),
        .lvl      (lvl),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_act <= 1'b0;
        end else begin
            brk_act <= cfg_q.brk_en && (brk_in == cfg_q.brk_pol);
        end
    end

    assign drive_ok = cfg_q.out_en && !brk_act && done;
    assign out_hi   = drive_ok && lvl;
    assign out_lo   = drive_ok && !lvl;

    // R9: an active break pulls both outputs low after the next edge
    a_r9_break: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.brk_en && (brk_in == cfg_q.brk_pol)) |=> (!out_hi && !out_lo));

endmodule

// File: tb/tb_deadband_gen.sv
module tb_deadband_gen;

    localparam int D     = 2;
    localparam int LIMIT = 60000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_code = 8'h00;
    logic       wr_out_en = 1'b0;
    logic       wr_brk_en = 1'b0;
    logic       wr_brk_pol = 1'b0;
    logic [1:0] lock_lvl = 2'b00;
    logic       brk_in = 1'b0;
    logic       out_hi;
    logic       out_lo;

    always #5 clk = ~clk;

    deadband_gen #(.TICK_DIV(D), .LOCK_W(2)) dut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .wr_en(wr_en),
        .wr_code(wr_code), .wr_out_en(wr_out_en), .wr_brk_en(wr_brk_en),
        .wr_brk_pol(wr_brk_pol), .lock_lvl(lock_lvl), .brk_in(brk_in),
        .out_hi(out_hi), .out_lo(out_lo)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit fin = 1'b0;
    bit mon_on = 1'b0;

    int         qc[$];
    logic [1:0] qs[$];
    string      qt[$];

    // bench model of the configuration and the expected output state {hi,lo}
    logic [1:0] mst = 2'b00;
    bit m_en = 0, m_be = 0, m_bp = 0, m_brk = 0, m_ref = 0;
    int m_dt = 0;

    function automatic bit m_blk();
        return m_be && (m_brk == m_bp);
    endfunction

    function automatic logic [1:0] settled();
        if (m_en && !m_blk()) return m_ref ? 2'b10 : 2'b01;
        return 2'b00;
    endfunction

    function automatic void push(int c, logic [1:0] s, string t);
        if (s != mst) begin
            qc.push_back(c);
            qs.push_back(s);
            qt.push_back(t);
            mst = s;
        end
    endfunction

    // called at a negedge: the change is sampled at the next posedge
    task automatic drv_level(bit v, int hold, string t);
        int e;
        ref_in = v;
        e = cyc + 1;
        m_ref = v;
        if (m_en && !m_blk()) begin
            if (m_dt == 0) begin
                push(e, v ? 2'b10 : 2'b01, t);
            end else begin
                push(e, 2'b00, t);
                if (m_dt * D < hold) push(e + m_dt * D, v ? 2'b10 : 2'b01, t);
            end
        end
        repeat (hold) @(negedge clk);
    endtask

    task automatic cfg_wr(logic [7:0] code, bit oe, bit be, bit bp, int dt, string t);
        wr_code = code; wr_out_en = oe; wr_brk_en = be; wr_brk_pol = bp;
        wr_en = 1'b1;
        if (lock_lvl == 2'b00) begin
            m_en = oe; m_be = be; m_bp = bp; m_dt = dt;
        end
        push(cyc + 1, settled(), t);
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_brk(bit v, string t);
        brk_in = v;
        m_brk = v;
        push(cyc + 1, settled(), t);
        repeat (6) @(negedge clk);
    endtask

    // monitor: every output change must match the head of the expected queue
    logic [1:0] prev = 2'b00;
    always @(negedge clk) begin
        if (mon_on && !fin) begin
            logic [1:0] cur;
            cur = {out_hi, out_lo};
            if (cur !== prev) begin
                n_chk++;
                if (qc.size() == 0) begin
                    n_fail++;
                    $display("FAIL unexpected change: actual state=%b at cycle %0d, expected no change",
                             cur, cyc);
                end else begin
                    int c;
                    logic [1:0] s;
                    string t;
                    c = qc.pop_front();
                    s = qs.pop_front();
                    t = qt.pop_front();
                    if (c != cyc || s !== cur) begin
                        n_fail++;
                        $display("FAIL %s: actual state=%b cycle=%0d, expected state=%b cycle=%0d",
                                 t, cur, cyc, s, c);
                    end
                end
                prev = cur;
            end
        end
    end

    task automatic finish_run();
        fin = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > LIMIT && !fin) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual cycle=%0d, expected below %0d", cyc, LIMIT);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        n_chk++;
        if (out_hi !== 1'b0 || out_lo !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: actual hi=%b lo=%b, expected 0 0", out_hi, out_lo);
        end
        prev = {out_hi, out_lo};
        mon_on = 1'b1;
        // R1: outputs disabled out of reset
        drv_level(1, 20, "R1");
        drv_level(0, 20, "R1");

        cfg_wr(8'h05, 1, 0, 1, 5, "R10");
        // R2: fine range
        drv_level(1, 40, "R2");
        drv_level(0, 40, "R2");
        cfg_wr(8'h7F, 1, 0, 1, 127, "R2");
        drv_level(1, 300, "R2");
        drv_level(0, 300, "R2");
        // R3: double-step range
        cfg_wr(8'h81, 1, 0, 1, 130, "R3");
        drv_level(1, 300, "R3");
        drv_level(0, 300, "R3");
        cfg_wr(8'hBF, 1, 0, 1, 254, "R3");
        drv_level(1, 600, "R3");
        drv_level(0, 600, "R3");
        // R4: x8 range
        cfg_wr(8'hC2, 1, 0, 1, 272, "R4");
        drv_level(1, 600, "R4");
        drv_level(0, 600, "R4");
        // R5: x16 range
        cfg_wr(8'hE1, 1, 0, 1, 528, "R5");
        drv_level(1, 1200, "R5");
        drv_level(0, 1200, "R5");
        cfg_wr(8'hFF, 1, 0, 1, 1008, "R5");
        drv_level(1, 2100, "R5");
        drv_level(0, 2100, "R5");
        // R11: zero dead band
        cfg_wr(8'h00, 1, 0, 1, 0, "R11");
        drv_level(1, 10, "R11");
        drv_level(0, 10, "R11");
        // R7: pulse shorter than, then equal to, the dead band (10 cycles)
        cfg_wr(8'h05, 1, 0, 1, 5, "R7");
        drv_level(1, 6, "R7");
        drv_level(0, 40, "R7");
        drv_level(1, 10, "R7");
        drv_level(0, 40, "R7");
        // R6: back-to-back edges with full dead band
        drv_level(1, 11, "R6");
        drv_level(0, 11, "R6");
        drv_level(1, 40, "R6");
        drv_level(0, 40, "R6");
        // R10: output enable off
        cfg_wr(8'h05, 0, 0, 1, 5, "R10");
        drv_level(1, 40, "R10");
        drv_level(0, 40, "R10");
        cfg_wr(8'h05, 1, 0, 1, 5, "R10");
        // R9: break ignored while disabled, then active high
        set_brk(1, "R9");
        set_brk(0, "R9");
        cfg_wr(8'h05, 1, 1, 1, 5, "R9");
        set_brk(1, "R9");
        set_brk(0, "R9");
        // R9: active-low polarity
        cfg_wr(8'h05, 1, 0, 0, 5, "R9");
        set_brk(1, "R9");
        cfg_wr(8'h05, 1, 1, 0, 5, "R9");
        set_brk(0, "R9");
        set_brk(1, "R9");
        // R8: lock blocks writes
        cfg_wr(8'h81, 1, 0, 1, 130, "R8");
        lock_lvl = 2'b01;
        cfg_wr(8'h05, 0, 1, 0, 5, "R8");
        drv_level(1, 300, "R8");
        drv_level(0, 300, "R8");
        set_brk(0, "R8");
        lock_lvl = 2'b10;
        cfg_wr(8'h00, 0, 0, 1, 0, "R8");
        drv_level(1, 300, "R8");
        drv_level(0, 300, "R8");

        repeat (20) @(negedge clk);
        while (qc.size() != 0) begin
            int c;
            logic [1:0] s;
            string t;
            c = qc.pop_front();
            s = qs.pop_front();
            t = qt.pop_front();
            n_chk++;
            n_fail++;
            $display("FAIL %s: actual no change, expected state=%b at cycle %0d", t, s, c);
        end
        finish_run();
    end

endmodule